// File: doc/BRIEF.md
# Mailbox Receive Queue

This block is the receive half of an inter-processor mailbox. Remote producers hand entries to it over a valid/ready stream. Each entry carries a 64-bit message and a 3-bit source channel number, and is stored in a circular queue. The local CPU reads the oldest entry through three registers: the channel number, the lower message word and the upper message word. It then writes a pop command to retire that entry.

The block does not report how many entries it holds. Instead it shows its raw write and read pointers and a full flag in one status word. Software works out the occupancy from those fields and from the depth register, which reads as the depth minus one. A not-empty interrupt is latched into a pending bit whenever the queue holds data and the interrupt is unmasked. Software acknowledges it by writing the pending bit. The pointers wrap explicitly at `DEPTH`, so depths that are not a power of two also work.

On the stream side, an entry is accepted on a rising edge where `push_valid` and `push_ready` are both high. `push_ready` is low while the queue is full. A producer may hold `push_valid` high while `push_ready` is low: the entry is not taken, and the pointers and stored entries do not change. Register writes take effect on the clock edge where `reg_wen` is high. Reads are combinational from `reg_addr`.

Top module: `mbox_rx_fifo`

## Requirements
- R1: After reset the status word (0x14) is 0, the interrupt mask (0x1C) reads 0x1F, the pending word (0x18) reads 0, `irq` is low and `push_ready` is high.
- R2: Register 0x24 reads `DEPTH`-1 (15 by default).
- R3: The oldest entry is visible at 0x00 (channel in bits 2:0, other bits zero), 0x04 (message bits 31:0) and 0x08 (message bits 63:32), and entries come out in the order they were accepted.
- R4: A write to 0x0C with bit 0 set retires the oldest entry and advances the read pointer. A write to 0x0C with bit 0 clear has no effect.
- R5: Status bits 23:16 hold the write pointer and bits 31:24 hold the read pointer, both zero-extended to 8 bits. Bit 2 is the full flag and all other bits read 0. Each pointer steps by one per accepted push or pop, and steps from `DEPTH`-1 to 0.
- R6: After `DEPTH` accepted pushes with no pop, the full flag is 1 and both pointers are equal. Further push attempts are dropped, leaving the pointers and the stored entries unchanged.
- R7: A pop command while the queue is empty leaves both pointers and the full flag unchanged.
- R8: Writing 0 to 0x10 clears both pointers and the full flag, which discards all entries. Writing a nonzero value to 0x10 has no effect.
- R9: While mask bit 0 (0x1C) is set, the pending bit stays 0. While it is clear and the queue is not empty, pending bit 0 of 0x18 and `irq` become 1 one cycle later.
- R10: Writing 0x18 with bit 0 set clears pending on that edge. It is set again on the next edge if entries remain, and stays 0 if the queue is empty.
- R11: `push_ready` equals the inverse of the full flag. A push is taken only when `push_valid` and `push_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Producer has an entry to deliver |
| push_ready | output | 1 | Queue can accept an entry |
| push_chan | input | 3 | Source channel of the entry |
| push_msg | input | 64 | Message payload |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Not-empty interrupt, equal to the pending bit |

## Verification
The checks assume that a register write lasts exactly one cycle, and that a pop command, a queue clear and an acknowledge are never combined with reset. They also assume that producers only ever see `push_ready` low when the queue is actually full. The stimulus drives every input half a cycle away from the sampling edge. It issues register writes as single-cycle strobes at word-aligned addresses. It attempts pushes while full only to observe that they are dropped, and it predicts pointer values with its own wrapping model of the queue.

// File: rtl/mbox_rx_pkg.sv
package mbox_rx_pkg;
  localparam int CHAN_W = 3;
  localparam int MSG_W  = 64;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic [MSG_W-1:0]  msg;
  } rx_entry_t;

  localparam logic [ADDR_W-1:0] OFS_CHAN  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_LOW   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_HIGH  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_POP   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_DEPTH = 6'h24;
endpackage

// File: rtl/mbox_rx_ptr.sv
module mbox_rx_ptr #(
  parameter int DEPTH = 16,
  parameter int PW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] nxt
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  // explicit wrap keeps non-power-of-two depths correct
  assign nxt = (ptr == LAST) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (clr)    ptr <= '0;
    else if (adv)    ptr <= nxt;
  end
endmodule

// File: rtl/mbox_rx_store.sv
module mbox_rx_store
  import mbox_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  rx_entry_t     wentry,
  input  logic [PW-1:0] raddr,
  output rx_entry_t     rentry
);
  rx_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wentry;
  end

  assign rentry = mem[raddr];
endmodule

// File: rtl/mbox_rx_regs.sv
module mbox_rx_regs
  import mbox_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  rx_entry_t         head,
  input  logic [PW-1:0]     wr_ptr,
  input  logic [PW-1:0]     rd_ptr,
  input  logic              full_q,
  input  logic              empty,
  output logic              pop_req,
  output logic              fifo_clr,
  output logic              irq_clr,
  output logic              mask_ne,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [4:0] mask_q;
  logic       pend_q;
  logic       mask_we;

  assign pop_req  = reg_wen && (reg_addr == OFS_POP)  && reg_wdata[0];
  assign fifo_clr = reg_wen && (reg_addr == OFS_CLR)  && (reg_wdata == '0);
  assign irq_clr  = reg_wen && (reg_addr == OFS_PEND) && reg_wdata[0];
  assign mask_we  = reg_wen && (reg_addr == OFS_MASK);
  assign mask_ne  = mask_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 5'h1F;
      pend_q <= 1'b0;
    end else begin
      if (mask_we) mask_q <= reg_wdata[4:0];
      if (irq_clr) pend_q <= 1'b0;
      else         pend_q <= pend_q | (!empty && !mask_q[0]);
    end
  end

  assign irq = pend_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CHAN:  reg_rdata = DATA_W'(head.chan);
      OFS_LOW:   reg_rdata = head.msg[31:0];
      OFS_HIGH:  reg_rdata = head.msg[63:32];
      OFS_STAT:  reg_rdata = {8'(rd_ptr), 8'(wr_ptr), 13'd0, full_q, 2'd0};
      OFS_PEND:  reg_rdata = DATA_W'(pend_q);
      OFS_MASK:  reg_rdata = DATA_W'(mask_q);
      OFS_DEPTH: reg_rdata = DATA_W'(DEPTH - 1);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mbox_rx_fifo.sv
module mbox_rx_fifo
  import mbox_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [CHAN_W-1:0] push_chan,
  input  logic [MSG_W-1:0]  push_msg,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int PW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic          full_q, empty;
  logic          pop_req, fifo_clr, irq_clr, mask_ne;
  logic          push_fire, pop_fire;
  rx_entry_t     head, wentry;

  assign empty      = (wr_ptr == rd_ptr) && !full_q;
  assign push_ready = !full_q;
  assign push_fire  = push_valid && push_ready && !fifo_clr;
  assign pop_fire   = pop_req && !empty && !fifo_clr;
  assign wentry     = '{chan: push_chan, msg: push_msg};

  mbox_rx_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wr (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .adv(push_fire),
    .ptr(wr_ptr), .nxt(wr_nxt));

  mbox_rx_ptr #(.DEPTH(DEPTH), .PW(PW)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .adv(pop_fire),
    .ptr(rd_ptr), .nxt(rd_nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      full_q <= 1'b0;
    else if (fifo_clr)               full_q <= 1'b0;
    else if (push_fire && !pop_fire) full_q <= (wr_nxt == rd_ptr);
    else if (pop_fire && !push_fire) full_q <= 1'b0;
  end

  mbox_rx_store #(.DEPTH(DEPTH), .PW(PW)) u_store (
    .clk(clk), .we(push_fire), .waddr(wr_ptr), .wentry(wentry),
    .raddr(rd_ptr), .rentry(head));

  mbox_rx_regs #(.DEPTH(DEPTH), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .head(head), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .full_q(full_q), .empty(empty), .pop_req(pop_req), .fifo_clr(fifo_clr),
    .irq_clr(irq_clr), .mask_ne(mask_ne), .reg_rdata(reg_rdata), .irq(irq));
endmodule

// File: rtl/mbox_rx_chk.sv
module mbox_rx_chk #(
  parameter int DEPTH = 16,
  parameter int PW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic          full_q,
  input logic          pop_req,
  input logic          fifo_clr,
  input logic          irq_clr,
  input logic          mask_ne,
  input logic          irq
);
  logic q_empty;
  assign q_empty = (wr_ptr == rd_ptr) && !full_q;

  a_r5_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wr_ptr) < DEPTH) && (int'(rd_ptr) < DEPTH));

  a_r6_full_ptr_eq: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (wr_ptr == rd_ptr));

  a_r6_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !fifo_clr) |=> (wr_ptr == $past(wr_ptr)));

  a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (q_empty && pop_req && !fifo_clr) |=> (rd_ptr == $past(rd_ptr)));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (wr_ptr == '0 && rd_ptr == '0 && !full_q));

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_ne && !irq) |=> !irq);

  a_r9_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_empty && !mask_ne && !irq_clr) |=> irq);

  a_r10_ack: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq);
endmodule

bind mbox_rx_fifo mbox_rx_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
  .full_q(full_q), .pop_req(pop_req), .fifo_clr(fifo_clr),
  .irq_clr(irq_clr), .mask_ne(mask_ne), .irq(irq));

// File: tb/tb_mbox_rx_fifo.sv
module tb_mbox_rx_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic        push_ready;
  logic [2:0]  push_chan = '0;
  logic [63:0] push_msg = '0;
  logic        reg_wen = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [66:0] sb [$];
  int exp_wr = 0, exp_rd = 0, exp_cnt = 0;

  mbox_rx_fifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_chan(push_chan), .push_msg(push_msg), .reg_wen(reg_wen),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] v);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = v;
    @(posedge clk); @(negedge clk);
    reg_wen = 1'b0;
  endtask

  function automatic logic [31:0] stat(input int w, input int r, input bit f);
    return {8'(r), 8'(w), 13'd0, f, 2'd0};
  endfunction

  task automatic check_stat(input string req);
    logic [31:0] v;
    rd_reg(6'h14, v);
    check(v == stat(exp_wr, exp_rd, exp_cnt == DEPTH), req, v,
          stat(exp_wr, exp_rd, exp_cnt == DEPTH));
  endtask

  // driver: offers one entry; records it in the scoreboard when it is expected to be taken
  task automatic drive(input logic [2:0] ch, input logic [63:0] m);
    push_valid = 1'b1; push_chan = ch; push_msg = m;
    @(posedge clk); @(negedge clk);
    push_valid = 1'b0;
    if (exp_cnt < DEPTH) begin
      sb.push_back({ch, m});
      exp_wr = (exp_wr + 1) % DEPTH;
      exp_cnt++;
    end
  endtask

  // monitor: reads the head, compares with the scoreboard, then pops
  task automatic take();
    logic [31:0] c, lo, hi;
    logic [66:0] e;
    e = sb.pop_front();
    rd_reg(6'h00, c); rd_reg(6'h04, lo); rd_reg(6'h08, hi);
    check(c == {29'd0, e[66:64]}, "R3 chan", c, {29'd0, e[66:64]});
    check(lo == e[31:0], "R3 low", lo, e[31:0]);
    check(hi == e[63:32], "R3 high", hi, e[63:32]);
    wr_reg(6'h0C, 32'h1);
    exp_rd = (exp_rd + 1) % DEPTH;
    exp_cnt--;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 depth
    check_stat("R1 status");
    rd_reg(6'h1C, v); check(v == 32'h1F, "R1 mask", v, 32'h1F);
    rd_reg(6'h18, v); check(v == 0, "R1 pending", v, 0);
    check(irq == 1'b0, "R1 irq", {31'd0, irq}, 0);
    check(push_ready == 1'b1, "R1 ready", {31'd0, push_ready}, 1);
    rd_reg(6'h24, v); check(v == DEPTH - 1, "R2 depth", v, DEPTH - 1);

    // R5 pointer fields, R9 masked stays quiet
    drive(3'd5, 64'hDEAD_BEEF_0123_4567);
    drive(3'd0, 64'h0000_0001_FFFF_FFFE);
    drive(3'd7, 64'hA5A5_5A5A_C3C3_3C3C);
    check_stat("R5 after pushes");
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R9 masked irq", {31'd0, irq}, 0);

    // R3 R4 in-order readout
    repeat (3) take();
    check_stat("R4 after pops");

    // R4 trigger with bit0 clear is ignored
    drive(3'd2, 64'h1111_2222_3333_4444);
    wr_reg(6'h0C, 32'h2);
    check_stat("R4 bit0 clear");
    take();

    // R7 pop while empty
    wr_reg(6'h0C, 32'h1);
    check_stat("R7 empty pop");

    // R6 fill, wrap (R5), drop while full, R11 ready
    for (int i = 0; i < DEPTH; i++) drive(3'(i), {32'(i * 7 + 1), 32'(~i)});
    check_stat("R6 full status");
    check(push_ready == 1'b0, "R11 ready low when full", {31'd0, push_ready}, 0);
    drive(3'd6, 64'hFFFF_FFFF_FFFF_FFFF);
    check_stat("R6 dropped push");
    for (int i = 0; i < DEPTH; i++) take();
    check_stat("R5 wrap after drain");
    check(push_ready == 1'b1, "R11 ready after drain", {31'd0, push_ready}, 1);

    // R9 interrupt, R10 acknowledge
    wr_reg(6'h1C, 32'h1E);
    drive(3'd1, 64'h0BAD_F00D_1234_5678);
    drive(3'd4, 64'h8765_4321_CAFE_BABE);
    @(negedge clk);
    check(irq == 1'b1, "R9 irq raised", {31'd0, irq}, 1);
    rd_reg(6'h18, v); check(v == 1, "R9 pending bit", v, 1);
    wr_reg(6'h18, 32'h1);
    check(irq == 1'b0, "R10 cleared on ack edge", {31'd0, irq}, 0);
    @(negedge clk);
    check(irq == 1'b1, "R10 re-armed with entries", {31'd0, irq}, 1);
    take(); take();
    wr_reg(6'h18, 32'h1);
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R10 stays clear when empty", {31'd0, irq}, 0);

    // R8 queue clear
    drive(3'd3, 64'h1);
    drive(3'd3, 64'h2);
    wr_reg(6'h10, 32'h5);
    check_stat("R8 nonzero write ignored");
    wr_reg(6'h10, 32'h0);
    sb.delete(); exp_wr = 0; exp_rd = 0; exp_cnt = 0;
    check_stat("R8 cleared");
    drive(3'd6, 64'h7777_8888_9999_AAAA);
    take();
    check_stat("R8 after refill");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule